// File: doc/BRIEF.md
# Iterative Binary64 Multiplier Front End

This block takes two IEEE-754 binary64 operands and produces the unrounded product in a form a later rounding stage can finish: a normalized 53-bit significand, one guard bit, one sticky bit, a signed intermediate exponent and the product sign. Operands that fix the answer alone (NaN, infinity, zero, and the invalid infinity-by-zero case) are resolved at once. They are returned as a finished 64-bit result that skips the rounding stage.

Control is a plain start/busy/done exchange rather than a stream. A request is taken on a clock edge where `start` is high and `busy` is low. A special result appears with `done` in the next cycle and `busy` never rises. Otherwise `busy` stays high while the datapath normalizes subnormal inputs and runs a radix-16 shift-and-add loop, and it drops in the same edge that raises `done`. There is no back-pressure: the results hold until the next accepted request, and `done` marks the cycle in which they first become valid. A `start` seen while `busy` is high has no effect.

Top module: `fpm_iter_mul`

## Requirements
- R1: `start` is taken only when `busy` is low. Each taken request gives `done` high for one cycle with `busy` low. A `start` pulse while `busy` is high changes neither the result nor the completion time of the running request.
- R2: The result sign is the XOR of the operand sign bits (bit 63). This holds for finite, zero and infinite results.
- R3: Infinity times zero, in either order, with `trap_en` low gives `special`=1, `invalid`=1 and `special_val` = 0x7FF8_0000_0000_0000.
- R4: An operand is a NaN when its exponent field (bits 62:52) is all ones and its fraction (bits 51:0) is non-zero. It is signaling when fraction bit 51 is 0, and quieting sets bit 51. If operand A is signaling, the result is quieted A with `invalid`=1. Else, if B is signaling, the result is quieted B with `invalid`=1. Else, if A is a NaN, the result is A. Else, if B is a NaN, the result is B. In the last two cases `invalid`=0.
- R5: Infinity (all-ones exponent field, zero fraction) times a non-zero, non-NaN value gives `special_val` = {sign, all-ones exponent, zero fraction} with `invalid`=0.
- R6: Zero (bits 62:0 all zero) times a finite value gives `special_val` = {sign, 63 zeros} with `invalid`=0.
- R7: For two normal operands, `res_exp` (13-bit two's complement) equals eA + eB − 1023, plus 1 when the significand product is 2 or more.
- R8: A subnormal operand whose highest set fraction bit is at position p counts as significand fraction<<(52−p) with biased exponent p − 51.
- R9: For non-special results, `res_sig` is the top 53 bits of the exact 106-bit significand product after normalization, so bit 52 is 1. `res_guard` is the next lower bit, and `res_sticky` is the OR of every bit below that.
- R10: For non-special requests, `busy` is high for exactly 17 + max(sA, sB) cycles, where s is 51 − p for a subnormal operand and 0 for a normal one.
- R11: A special or trapped request asserts `done` in the cycle after it is taken, and `busy` stays low throughout.
- R12: An invalid case (R3 or a signaling NaN under R4) with `trap_en` high gives `trap`=1, `special`=0 and `invalid`=0. For all other inputs `trap_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken when busy is low |
| opa | input | 64 | Operand A, binary64 |
| opb | input | 64 | Operand B, binary64 |
| trap_en | input | 1 | Invalid operations trap instead of returning a NaN |
| busy | output | 1 | Iterative datapath occupied |
| done | output | 1 | One-cycle completion strobe |
| special | output | 1 | special_val holds the final result |
| special_val | output | 64 | Finished result for special cases |
| invalid | output | 1 | Invalid flag for the special result |
| trap | output | 1 | Invalid operation trapped, no result |
| res_sign | output | 1 | Product sign |
| res_exp | output | 13 | Signed intermediate biased exponent |
| res_sig | output | 53 | Normalized significand, leading one at bit 52 |
| res_guard | output | 1 | Bit below the significand LSB |
| res_sticky | output | 1 | OR of all lower product bits |

## Verification
Random normal pairs exercise both product ranges, below 2 and 2 or more, which the exponent increment and the guard position tell apart. Random subnormals on one side or both separate the normalization shift count, visible in the latency, from the exponent correction. Mixes of zero, infinity, quiet NaN and signaling NaN in both operand positions, with the trap enable set both ways, expose the NaN priority and the order of operands in the invalid checks. Directed cases cover exact products with zero sticky, the smallest subnormal, the largest normal squared, and a start pulse during a running request.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PREP = 3'd1,
    ST_MUL  = 3'd2,
    ST_NORM = 3'd3,
    ST_FIX  = 3'd4
  } fpm_state_e;

  typedef struct packed {
    logic zero;
    logic inf;
    logic nan;
    logic snan;
  } fpm_class_t;
endpackage

// File: rtl/fpm_classify.sv
module fpm_classify #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         trap_en,
  output logic         special_o,
  output logic [W-1:0] special_val_o,
  output logic         invalid_o,
  output logic         trap_o
);
  import fpm_pkg::*;

  localparam logic [W-1:0] QUIET_BIT = W'(1) << (FRAC_W - 1);
  localparam logic [W-1:0] DEF_NAN   = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  fpm_class_t ca, cb;
  logic       sgn, hit, inv;
  logic [W-1:0] val;

  function automatic fpm_class_t classify(input logic [W-1:0] x);
    fpm_class_t c;
    logic ones;
    ones   = &x[W-2 -: EXP_W];
    c.zero = (x[W-2:0] == '0);
    c.inf  = ones && (x[FRAC_W-1:0] == '0);
    c.nan  = ones && (x[FRAC_W-1:0] != '0);
    c.snan = c.nan && !x[FRAC_W-1];
    return c;
  endfunction

  assign ca  = classify(opa);
  assign cb  = classify(opb);
  assign sgn = opa[W-1] ^ opb[W-1];

  always_comb begin
    hit = 1'b0;
    inv = 1'b0;
    val = '0;
    if (ca.nan) begin
      hit = 1'b1;
      if (ca.snan) begin
        inv = 1'b1;
        val = opa | QUIET_BIT;
      end else if (cb.snan) begin
        inv = 1'b1;
        val = opb | QUIET_BIT;
      end else begin
        val = opa;
      end
    end else if (cb.nan) begin
      hit = 1'b1;
      inv = cb.snan;
      val = opb | QUIET_BIT;
    end else if ((ca.inf && cb.zero) || (ca.zero && cb.inf)) begin
      hit = 1'b1;
      inv = 1'b1;
      val = DEF_NAN;
    end else if (ca.inf || cb.inf) begin
      hit = 1'b1;
      val = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (ca.zero || cb.zero) begin
      hit = 1'b1;
      val = {sgn, {(W-1){1'b0}}};
    end
  end

  assign trap_o        = inv && trap_en;
  assign special_o     = hit && !trap_o;
  assign invalid_o     = inv && !trap_o;
  assign special_val_o = val;
endmodule

// File: rtl/fpm_prenorm.sv
module fpm_prenorm #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [EXP_W+FRAC_W-1:0] mag,
  input  logic                    step,
  output logic [FRAC_W:0]         sig_o,
  output logic                    need_o
);
  logic [FRAC_W:0] sig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig <= '0;
    end else if (load) begin
      if (|mag[EXP_W+FRAC_W-1 -: EXP_W]) sig <= {1'b1, mag[FRAC_W-1:0]};
      else                               sig <= {mag[FRAC_W-1:0], 1'b0};
    end else if (step && !sig[FRAC_W]) begin
      sig <= sig << 1;
    end
  end

  assign sig_o  = sig;
  assign need_o = !sig[FRAC_W];

  // R8: once the leading one reaches the hidden position it stays there
  a_r8_lead_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && sig[FRAC_W]) |=> sig[FRAC_W]);
endmodule

// File: rtl/fpm_mac.sv
module fpm_mac #(
  parameter int SIG_W  = 53,
  parameter int RB     = 4,
  parameter int PAD    = 7,
  localparam int ITERS = (SIG_W + RB - 1) / RB,
  localparam int MQ_W  = ITERS * RB,
  localparam int ACC_W = SIG_W + PAD + RB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             nshift,
  input  logic [SIG_W-1:0] mcand,
  input  logic [SIG_W-1:0] mplier,
  output logic [ACC_W-1:0] acc_o,
  output logic             sticky_o
);
  logic [ACC_W-1:0] acc, part;
  logic [MQ_W-1:0]  mq;
  logic             sticky;
  logic [ACC_W-1:0] term [RB];

  for (genvar j = 0; j < RB; j++) begin : g_term
    assign term[j] = mq[j] ? (ACC_W'(mcand) << (PAD + j)) : '0;
  end

  always_comb begin
    part = '0;
    for (int j = 0; j < RB; j++) part = part + term[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      mq     <= '0;
      sticky <= 1'b0;
    end else if (clear) begin
      acc    <= '0;
      mq     <= MQ_W'(mplier);
      sticky <= 1'b0;
    end else if (step) begin
      sticky <= sticky | (|acc[RB-1:0]);
      acc    <= (acc >> RB) + part;
      mq     <= mq >> RB;
    end else if (nshift) begin
      acc <= acc << 1;
    end
  end

  assign acc_o    = acc;
  assign sticky_o = sticky;

  // R9: bits that leave the accumulator are never forgotten
  a_r9_sticky_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (step && sticky) |=> sticky);
endmodule

// File: rtl/fpm_iter_mul.sv
module fpm_iter_mul #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int RB     = 4,
  parameter int PAD    = 7,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int SIG_W = FRAC_W + 1,
  localparam int EO_W  = EXP_W + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  input  logic            trap_en,
  output logic            busy,
  output logic            done,
  output logic            special,
  output logic [W-1:0]    special_val,
  output logic            invalid,
  output logic            trap,
  output logic            res_sign,
  output logic [EO_W-1:0] res_exp,
  output logic [SIG_W-1:0] res_sig,
  output logic            res_guard,
  output logic            res_sticky
);
  import fpm_pkg::*;

  localparam int ITERS = (SIG_W + RB - 1) / RB;
  localparam int ACC_W = SIG_W + PAD + RB;
  localparam int TOP   = 2 * SIG_W - 1 + PAD - RB * (ITERS - 1);
  localparam int GRD   = TOP - SIG_W;
  localparam int CNT_W = $clog2(ITERS);
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ITERS - 1);

  fpm_state_e state;
  logic [CNT_W-1:0] cnt;
  logic signed [EO_W-1:0] exp_r, exp_init;
  logic sign_r, done_r, spec_r, inv_r, trap_r;
  logic [W-1:0] sval_r;

  logic c_spec, c_inv, c_trap;
  logic [W-1:0] c_val;
  logic [W-1:0] ops [2];
  logic [SIG_W-1:0] sigs [2];
  logic [1:0] need;
  logic pn_load, mac_clear, mac_step, mac_nshift, mac_sticky;
  logic [ACC_W-1:0] acc;

  fpm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
    .opa(opa), .opb(opb), .trap_en(trap_en),
    .special_o(c_spec), .special_val_o(c_val),
    .invalid_o(c_inv), .trap_o(c_trap)
  );

  assign ops[0] = opa;
  assign ops[1] = opb;
  assign pn_load = (state == ST_IDLE) && start && !c_spec && !c_trap;

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    fpm_prenorm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pn (
      .clk(clk), .rst_n(rst_n), .load(pn_load),
      .mag(ops[g][W-2:0]), .step(state == ST_PREP),
      .sig_o(sigs[g]), .need_o(need[g])
    );
  end

  assign mac_clear  = (state == ST_PREP) && (need == 2'b00);
  assign mac_step   = (state == ST_MUL);
  assign mac_nshift = ((state == ST_NORM) || (state == ST_FIX)) && !acc[TOP];

  fpm_mac #(.SIG_W(SIG_W), .RB(RB), .PAD(PAD)) u_mac (
    .clk(clk), .rst_n(rst_n), .clear(mac_clear), .step(mac_step),
    .nshift(mac_nshift), .mcand(sigs[1]), .mplier(sigs[0]),
    .acc_o(acc), .sticky_o(mac_sticky)
  );

  assign exp_init = $signed(EO_W'(opa[W-2 -: EXP_W])) + $signed(EO_W'(opb[W-2 -: EXP_W]))
                  - $signed(EO_W'(BIAS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      exp_r  <= '0;
      sign_r <= 1'b0;
      done_r <= 1'b0;
      spec_r <= 1'b0;
      inv_r  <= 1'b0;
      trap_r <= 1'b0;
      sval_r <= '0;
    end else begin
      done_r <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          sign_r <= opa[W-1] ^ opb[W-1];
          spec_r <= c_spec;
          sval_r <= c_val;
          inv_r  <= c_inv;
          trap_r <= c_trap;
          if (c_spec || c_trap) begin
            done_r <= 1'b1;
          end else begin
            exp_r <= exp_init;
            state <= ST_PREP;
          end
        end
        ST_PREP: if (need == 2'b00) begin
          cnt   <= '0;
          state <= ST_MUL;
        end else begin
          exp_r <= exp_r - EO_W'(need[0]) - EO_W'(need[1]);
        end
        ST_MUL: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_NORM;
        end
        ST_NORM: begin
          if (acc[TOP]) exp_r <= exp_r + 1'b1;
          state <= ST_FIX;
        end
        ST_FIX: if (acc[TOP]) begin
          done_r <= 1'b1;
          state  <= ST_IDLE;
        end else begin
          exp_r <= exp_r - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state != ST_IDLE);
  assign done        = done_r;
  assign special     = spec_r;
  assign special_val = sval_r;
  assign invalid     = inv_r;
  assign trap        = trap_r;
  assign res_sign    = sign_r;
  assign res_exp     = exp_r;
  assign res_sig     = acc[TOP -: SIG_W];
  assign res_guard   = acc[GRD];
  assign res_sticky  = mac_sticky | (|acc[GRD-1:0]);

  // R1: completion is only reported once the datapath is free
  a_r1_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R1: a start during busy must not disturb the latched request
  a_r1_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(res_sign));
  // R8: both significands are normalized before the product loop
  a_r8_mul_norm: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MUL) |-> (sigs[0][SIG_W-1] && sigs[1][SIG_W-1]));
  // R9: the delivered significand carries its leading one and no overflow bits
  a_r9_result_norm: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !special && !trap) |-> (res_sig[SIG_W-1] && (acc[ACC_W-1:TOP+1] == '0)));
  // R12: a trapped request never also presents a result
  a_r12_trap_excl: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(special && trap));
  // R4: an invalid flag always comes with a quiet NaN
  a_r4_nan_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (done && invalid) |-> (special && (&special_val[W-2 -: EXP_W]) && special_val[FRAC_W-1]));
endmodule

// File: tb/sim_fpm_iter_mul.sv
`timescale 1ns/1ps
module sim_fpm_iter_mul;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, trap_en = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic busy, done, special, invalid, trap, res_sign, res_guard, res_sticky;
  logic [63:0] special_val;
  logic [12:0] res_exp;
  logic [52:0] res_sig;
  int n_vec = 0, n_bad = 0;

  always #2 clk = ~clk;

  fpm_iter_mul u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb), .trap_en(trap_en),
    .busy(busy), .done(done), .special(special), .special_val(special_val),
    .invalid(invalid), .trap(trap), .res_sign(res_sign), .res_exp(res_exp),
    .res_sig(res_sig), .res_guard(res_guard), .res_sticky(res_sticky)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit f_nan(input logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction
  function automatic bit f_snan(input logic [63:0] x);
    return f_nan(x) && (x[51] == 1'b0);
  endfunction
  function automatic bit f_inf(input logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] == 0);
  endfunction
  function automatic bit f_zero(input logic [63:0] x);
    return x[62:0] == 0;
  endfunction

  function automatic void unpack(input logic [63:0] x, output logic [52:0] m,
                                 output int e, output int sh);
    int p = 0;
    if (x[62:52] != 0) begin
      m = {1'b1, x[51:0]}; e = int'(x[62:52]); sh = 0;
    end else begin
      for (int i = 0; i < 52; i++) if (x[i]) p = i;
      m = 53'(x[51:0]) << (52 - p); e = p - 51; sh = 51 - p;
    end
  endfunction

  function automatic void model(input logic [63:0] a, b, input logic te,
      output bit spec, output logic [63:0] sv, output bit inv, output bit trp,
      output bit sg, output logic [12:0] ex, output logic [52:0] sig,
      output bit gd, output bit st, output int lat);
    logic [52:0] ma, mb;
    logic [105:0] pr;
    int ea, eb, sa, sb, e;
    sg = a[63] ^ b[63];
    spec = 1'b1; inv = 1'b0; trp = 1'b0; sv = '0;
    ex = '0; sig = '0; gd = 1'b0; st = 1'b0; lat = 0;
    if (f_nan(a) && f_snan(a)) begin inv = 1; sv = a | (64'd1 << 51); end
    else if (f_nan(a) && f_snan(b)) begin inv = 1; sv = b | (64'd1 << 51); end
    else if (f_nan(a)) sv = a;
    else if (f_nan(b)) begin inv = f_snan(b); sv = b | (64'd1 << 51); end
    else if ((f_inf(a) && f_zero(b)) || (f_inf(b) && f_zero(a))) begin
      inv = 1; sv = 64'h7FF8_0000_0000_0000;
    end
    else if (f_inf(a) || f_inf(b)) sv = {sg, 11'h7FF, 52'd0};
    else if (f_zero(a) || f_zero(b)) sv = {sg, 63'd0};
    else spec = 1'b0;
    if (inv && te) begin trp = 1; inv = 0; spec = 0; end
    if (!spec && !trp) begin
      unpack(a, ma, ea, sa);
      unpack(b, mb, eb, sb);
      pr = 106'(ma) * 106'(mb);
      e = ea + eb - 1023;
      if (pr[105]) begin
        e++; sig = pr[105:53]; gd = pr[52]; st = |pr[51:0];
      end else begin
        sig = pr[104:52]; gd = pr[51]; st = |pr[50:0];
      end
      ex = e[12:0];
      lat = 17 + ((sa > sb) ? sa : sb);
    end
  endfunction

  // poke >= 0: pulse start with other operands that many cycles into the request
  task automatic run(input logic [63:0] a, b, input logic te, input int poke);
    bit spec, inv, trp, sg, gd, st;
    logic [63:0] sv;
    logic [12:0] ex;
    logic [52:0] sig;
    int lat, cyc, bcnt;
    model(a, b, te, spec, sv, inv, trp, sg, ex, sig, gd, st, lat);
    @(negedge clk);
    opa = a; opb = b; trap_en = te; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cyc = 0; bcnt = 0;
    while (!done && cyc < 400) begin
      if (busy) bcnt++;
      cyc++;
      if (cyc == poke) begin start = 1'b1; opa = ~a; opb = {b[63:52], ~b[51:0]}; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL R1 request never completed actual=busy expected=done");
      return;
    end
    chk("R1 busy low with done", 64'(busy), 64'd0);
    chk("R12 trap output", 64'(trap), 64'(trp));
    chk("R3/R4/R5/R6 special flag", 64'(special), 64'(spec));
    if (spec) begin
      chk("R11 special latency", 64'(cyc), 64'd0);
      chk("R2/R3/R4/R5/R6 special value", special_val, sv);
      chk("R3/R4 invalid flag", 64'(invalid), 64'(inv));
    end else if (trp) begin
      chk("R11 R12 trap latency", 64'(cyc), 64'd0);
      chk("R12 invalid low on trap", 64'(invalid), 64'd0);
    end else begin
      chk("R10 busy cycles", 64'(bcnt), 64'(lat));
      chk("R2 sign", 64'(res_sign), 64'(sg));
      chk("R7 R8 exponent", 64'(res_exp), 64'(ex));
      chk("R9 significand", 64'(res_sig), 64'(sig));
      chk("R9 guard", 64'(res_guard), 64'(gd));
      chk("R9 sticky", 64'(res_sticky), 64'(st));
    end
    @(negedge clk);
    chk("R1 done is a single pulse", 64'(done), 64'd0);
  endtask

  function automatic logic [63:0] gen_op();
    logic [51:0] f = {$urandom, $urandom};
    logic s = 1'($urandom);
    case ($urandom % 10)
      0, 1, 2, 3, 4: return {s, 11'(1 + ($urandom % 2046)), f};
      5: begin
        f = f >> ($urandom % 52);
        if (f == 0) f = 52'd1;
        return {s, 11'd0, f};
      end
      6: return {s, 63'd0};
      7: return {s, 11'h7FF, 52'd0};
      8: return {s, 11'h7FF, 1'b1, f[50:0]};
      default: return {s, 11'h7FF, 1'b0, f[50:1], 1'b1};
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL R1 watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk("R1 reset busy", 64'(busy), 64'd0);
    chk("R1 reset done", 64'(done), 64'd0);
    rst_n = 1'b1;
    // directed corners
    run(64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1'b0, -1);   // R7 1*1
    run(64'h3FF8_0000_0000_0000, 64'hBFF8_0000_0000_0000, 1'b0, -1);   // R7 R2 product >= 2
    run(64'h7FEF_FFFF_FFFF_FFFF, 64'h7FEF_FFFF_FFFF_FFFF, 1'b0, -1);   // R9 max squared
    run(64'h0000_0000_0000_0001, 64'h3FF0_0000_0000_0000, 1'b0, -1);   // R8 R10 smallest subnormal
    run(64'h8000_0000_0000_0003, 64'h000F_FFFF_FFFF_FFFF, 1'b0, -1);   // R8 both subnormal
    run(64'h7FF0_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, -1);   // R3 inf*zero
    run(64'h0000_0000_0000_0000, 64'hFFF0_0000_0000_0000, 1'b1, -1);   // R12 zero*inf trapped
    run(64'h7FF0_0000_0000_0001, 64'h7FF0_0000_0000_0002, 1'b0, -1);   // R4 both signaling
    run(64'h7FF8_0000_0000_0005, 64'hFFF0_0000_0000_0007, 1'b0, -1);   // R4 quiet A, signaling B
    run(64'h7FF0_0000_0000_0000, 64'hFFF8_0000_0000_0009, 1'b0, -1);   // R4 inf*quiet NaN
    run(64'hFFF0_0000_0000_0000, 64'h0000_0000_0000_0001, 1'b1, -1);   // R5 R12 no effect
    run(64'h8000_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b1, -1);   // R6 signed zero
    run(64'h4008_0000_0000_0001, 64'h3FF1_0000_0000_0003, 1'b0, 5);    // R1 start ignored while busy
    for (int i = 0; i < 400; i++) run(gen_op(), gen_op(), 1'($urandom), -1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule